// File: doc/BRIEF.md
# EEPROM Access Engine with Burst Loader

This block gives a host processor access to an external byte-wide EEPROM through a small set of registers. For a single access, the host writes an EEPROM address and, for a write, a data byte. It then sets a read or a write request bit in the control register. The engine issues one transaction on a request/acknowledge byte port and clears the request bit when the transaction completes. A read result is valid in the data register once the read bit reads back as zero.

A burst mode loads memory-initialisation records from the EEPROM into a 24-bit internal memory write port. Each record is three consecutive bytes: the low address byte, then the high address byte, then a data byte. The memory address is built from a 9-bit base register, which gives the upper bits, and the low 15 bits of the record address. The top record-address bit is dropped. A record whose address is 0xFFFF ends the burst. The first burst EEPROM address depends on history. It is 0 if no access has completed since reset. Otherwise it is one past the last EEPROM address touched.

Top module: `eeprom_access_engine`

## Requirements
- R1: After reset the control register (offset 0) reads 0, the last-address register (offset 5) reads 0 (bit 16 = 0 means untouched), and ee_req and mem_we are low.
- R2: Writing control with bit 1 set starts a read of the EEPROM byte at the address register (offset 1). Bit 1 reads 1 until the acknowledge. It then reads 0, and the data register (offset 2) holds the byte. ee_req, ee_addr and ee_we stay stable until acknowledged.
- R3: Writing control with bit 0 set (and bit 1 clear) issues one transaction with ee_we=1, ee_addr = the address register and ee_wdata = the data register. Bit 0 clears when the transaction is acknowledged. The data register keeps only bits [7:0] of a host write.
- R4: Control bit 4 reads 1 while a single access or a burst is active. While it is 1, writes to control and to the burst-start register (offset 3) start nothing, and ee_req is low whenever bit 4 is 0.
- R5: Writing 1 to bit 0 of the burst-start register while idle starts a burst. If no access has completed since reset, the burst reads from EEPROM address 0 upward. Burst transactions never have ee_we set.
- R6: If an access has completed since reset, a burst starts at the last touched EEPROM address plus one.
- R7: Each complete record gives exactly one single-cycle mem_we pulse. mem_addr = {base register (offset 4) bits [8:0], record address bits [14:0]}, and mem_wdata is the record's data byte.
- R8: A record address of 0xFFFF ends the burst without a data byte and without a mem_we pulse. Burst-start bit 0 then reads 0.
- R9: Every acknowledged transaction, single or burst, sets the last-address register to that transaction's EEPROM address with bit 16 = 1.
- R10: If control is written with bits 1 and 0 both set, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 control, 1 address, 2 data, 3 burst start, 4 base, 5 last address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ee_req | output | 1 | EEPROM transaction request, held until acknowledged |
| ee_we | output | 1 | Transaction is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle transaction acknowledge |
| ee_rdata | input | 8 | Byte read, valid with ee_ack |
| mem_we | output | 1 | Internal memory write pulse |
| mem_addr | output | 24 | Internal memory address |
| mem_wdata | output | 8 | Internal memory data |

## Verification
The first burst runs straight after reset. It uses a record whose address has bit 15 set, which shows both the start-at-zero rule and that the top address bit is dropped. A later burst runs after single reads and writes, which separates the resume-after-last-address rule from a start at zero. A slow-responding EEPROM model holds a read in flight while the bench writes new requests and a burst start. This tells the busy interlock apart from queueing. A control write with both request bits set shows which request has priority.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] REG_ADDR  = 3'd1;
    localparam logic [REG_AW-1:0] REG_DATA  = 3'd2;
    localparam logic [REG_AW-1:0] REG_BURST = 3'd3;
    localparam logic [REG_AW-1:0] REG_BASE  = 3'd4;
    localparam logic [REG_AW-1:0] REG_LAST  = 3'd5;
    localparam int BIT_WR   = 0;
    localparam int BIT_RD   = 1;
    localparam int BIT_BUSY = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_BURST
    } eep_state_e;
endpackage

// File: rtl/eep_record_asm.sv
module eep_record_asm #(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              take_i,
    input  logic [DW-1:0]     byte_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              end_o,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    localparam int LOW_W = MEM_AW - BASE_W;

    typedef struct packed {
        logic [1:0]        idx;
        logic [DW-1:0]     lo;
        logic [DW-1:0]     hi;
        logic              we;
        logic [MEM_AW-1:0] maddr;
        logic [DW-1:0]     mdata;
    } asm_t;

    asm_t q, d;
    logic [2*DW-1:0] rec_addr;

    always_comb begin
        rec_addr = {q.hi, q.lo};
        end_o    = take_i && (q.idx == 2'd1) && (&{byte_i, q.lo});
        d        = q;
        d.we     = 1'b0;
        if (start_i) begin
            d.idx = 2'd0;
        end
        if (take_i) begin
            case (q.idx)
                2'd0: begin
                    d.lo  = byte_i;
                    d.idx = 2'd1;
                end
                2'd1: begin
                    d.hi  = byte_i;
                    d.idx = end_o ? 2'd0 : 2'd2;
                end
                default: begin
                    d.we    = 1'b1;
                    d.maddr = {base_i, rec_addr[LOW_W-1:0]};
                    d.mdata = byte_i;
                    d.idx   = 2'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.mdata;
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic [BASE_W-1:0] base_o,
    output logic              burst_start_o,
    output logic              burst_take_o,
    input  logic              burst_end_i,
    output logic              busy_o,
    output logic              touched_o
);
    localparam logic [EE_AW-1:0] ONE = {{(EE_AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        eep_state_e        st;
        logic              rd;
        logic              wr;
        logic              burst;
        logic [EE_AW-1:0]  addr;
        logic [DW-1:0]     data;
        logic [BASE_W-1:0] base;
        logic [EE_AW-1:0]  last;
        logic              touched;
        logic [EE_AW-1:0]  ptr;
        logic              req;
        logic              we;
    } ctrl_t;

    ctrl_t q, d;
    logic  take;
    logic  idle;

    always_comb begin
        d             = q;
        idle          = (q.st == ST_IDLE);
        take          = q.req && ee_ack;
        burst_start_o = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                REG_ADDR: d.addr = reg_wdata[EE_AW-1:0];
                REG_DATA: d.data = reg_wdata[DW-1:0];
                REG_BASE: d.base = reg_wdata[BASE_W-1:0];
                REG_CTRL: begin
                    if (idle && (reg_wdata[BIT_RD] || reg_wdata[BIT_WR])) begin
                        d.st  = ST_SINGLE;
                        d.req = 1'b1;
                        d.ptr = q.addr;
                        d.rd  = reg_wdata[BIT_RD];
                        d.wr  = !reg_wdata[BIT_RD];
                        d.we  = !reg_wdata[BIT_RD];
                    end
                end
                REG_BURST: begin
                    if (idle && reg_wdata[0]) begin
                        d.st          = ST_BURST;
                        d.burst       = 1'b1;
                        d.req         = 1'b1;
                        d.we          = 1'b0;
                        d.ptr         = q.touched ? q.last + ONE : '0;
                        burst_start_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (take) begin
            d.last    = q.ptr;
            d.touched = 1'b1;
            if (q.st == ST_SINGLE) begin
                if (q.rd) d.data = ee_rdata;
                d.rd  = 1'b0;
                d.wr  = 1'b0;
                d.req = 1'b0;
                d.we  = 1'b0;
                d.st  = ST_IDLE;
            end else begin
                d.ptr = q.ptr + ONE;
                if (burst_end_i) begin
                    d.burst = 1'b0;
                    d.req   = 1'b0;
                    d.st    = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[BIT_BUSY] = (q.st != ST_IDLE);
                reg_rdata[BIT_RD]   = q.rd;
                reg_rdata[BIT_WR]   = q.wr;
            end
            REG_ADDR:  reg_rdata[EE_AW-1:0]  = q.addr;
            REG_DATA:  reg_rdata[DW-1:0]     = q.data;
            REG_BURST: reg_rdata[0]          = q.burst;
            REG_BASE:  reg_rdata[BASE_W-1:0] = q.base;
            REG_LAST: begin
                reg_rdata[EE_AW-1:0] = q.last;
                reg_rdata[EE_AW]     = q.touched;
            end
            default: ;
        endcase
    end

    assign ee_req       = q.req;
    assign ee_we        = q.we;
    assign ee_addr      = q.ptr;
    assign ee_wdata     = q.data;
    assign base_o       = q.base;
    assign burst_take_o = take && (q.st == ST_BURST);
    assign busy_o       = (q.st != ST_IDLE);
    assign touched_o    = q.touched;
endmodule

// File: rtl/eeprom_access_engine.sv
module eeprom_access_engine
    import eep_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9,
    parameter int MEM_AW = 24,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    logic [BASE_W-1:0] base_w;
    logic              start_w;
    logic              take_w;
    logic              end_w;
    logic              busy_w;
    logic              touched_w;

    eep_ctrl #(
        .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .REG_W(REG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .base_o(base_w), .burst_start_o(start_w), .burst_take_o(take_w),
        .burst_end_i(end_w), .busy_o(busy_w), .touched_o(touched_w)
    );

    eep_record_asm #(
        .EE_AW(EE_AW), .DW(DW), .BASE_W(BASE_W), .MEM_AW(MEM_AW)
    ) u_asm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_w), .take_i(take_w), .byte_i(ee_rdata), .base_i(base_w),
        .end_o(end_w), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/eeprom_access_engine_chk.sv
module eeprom_access_engine_chk #(
    parameter int EE_AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ee_req,
    input logic             ee_ack,
    input logic             ee_we,
    input logic [EE_AW-1:0] ee_addr,
    input logic             mem_we,
    input logic             busy,
    input logic             burst_take,
    input logic             touched
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && !ee_ack |=> ee_req && $stable(ee_addr) && $stable(ee_we)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_req); // R4
    AST_BURST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_take |-> !ee_we); // R5
    AST_MEM_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R7
    AST_TOUCH_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack |=> touched); // R9
endmodule

bind eeprom_access_engine eeprom_access_engine_chk #(.EE_AW(EE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
    .ee_addr(ee_addr), .mem_we(mem_we), .busy(busy_w), .burst_take(take_w),
    .touched(touched_w)
);

// File: tb/eeprom_access_engine_bench.sv
module eeprom_access_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int errors = 0;
    int checks = 0;
    int lat = 1;
    int wr_count = 0;
    int ack_count = 0;
    logic [15:0] last_wr_addr = '0;
    logic [7:0] model [int];
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    eeprom_access_engine u_eeprom_access_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] mval(int a);
        if (model.exists(a)) return model[a];
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // EEPROM model: acknowledges a held request after lat cycles
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            if (ee_ack) begin
                ee_ack <= 1'b0;
                cnt = 0;
            end else if (ee_req) begin
                cnt++;
                if (cnt >= lat) begin
                    ee_ack   <= 1'b1;
                    ee_rdata <= mval(int'(ee_addr));
                    ack_count++;
                    if (ee_we) begin
                        model[int'(ee_addr)] = ee_wdata;
                        wr_count++;
                        last_wr_addr = ee_addr;
                    end
                    cnt = 0;
                end
            end
        end
    end

    // scoreboard monitor for the memory write port
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_we) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected mem_we", {mem_addr, mem_wdata}, 32'hFFFF_FFFF);
                end else begin
                    chk("R7 record", {mem_addr, mem_wdata}, exp_q.pop_front());
                end
            end
        end
    end

    task automatic push_rec(logic [8:0] base, logic [15:0] a, logic [7:0] dat);
        exp_q.push_back({base, a[14:0], dat});
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(string tag);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(3'd0, v);
            if (!v[4]) return;
        end
        chk({tag, " timeout"}, 32'd1, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wc, ac;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd5, v); chk("R1 last", v, 0);
        chk("R1 ee_req", {31'd0, ee_req}, 0);
        chk("R1 mem_we", {31'd0, mem_we}, 0);

        // first burst, from address 0
        model[0] = 8'h34; model[1] = 8'h92; model[2] = 8'hAB;
        model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h11;
        model[6] = 8'hFF; model[7] = 8'hFF;
        wr(3'd4, 32'h15A);
        push_rec(9'h15A, 16'h9234, 8'hAB);
        push_rec(9'h15A, 16'h0000, 8'h11);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk("R5 burst bit set", v, 1);
        wait_idle("R5");
        rd(3'd3, v); chk("R8 burst bit cleared", v, 0);
        chk("R8 records left", exp_q.size(), 0);
        rd(3'd5, v); chk("R5 R9 last after burst", v, 32'h1_0007);

        // single read with slow EEPROM, plus ignored requests
        model[16'h100] = 8'hC3;
        lat = 6;
        wr(3'd1, 32'h100);
        wc = wr_count; ac = ack_count;
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R2 R4 ctrl busy", v, 32'h12);
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h1);
        wait_idle("R2");
        rd(3'd0, v); chk("R2 ctrl cleared", v, 0);
        rd(3'd2, v); chk("R2 data", v, 32'hC3);
        chk("R4 no write started", wr_count, wc);
        chk("R4 one transaction", ack_count, ac + 1);
        rd(3'd3, v); chk("R4 burst ignored", v, 0);
        rd(3'd5, v); chk("R9 last after read", v, 32'h1_0100);
        lat = 2;

        // single write
        wr(3'd1, 32'h200);
        wr(3'd2, 32'h15C);
        rd(3'd2, v); chk("R3 data width", v, 32'h5C);
        wc = wr_count;
        wr(3'd0, 32'h1);
        wait_idle("R3");
        chk("R3 one write", wr_count, wc + 1);
        chk("R3 write addr", last_wr_addr, 16'h200);
        chk("R3 written byte", mval(16'h200), 8'h5C);
        rd(3'd0, v); chk("R3 ctrl cleared", v, 0);

        // both bits: read wins
        model[16'h300] = 8'h77;
        wr(3'd1, 32'h300);
        wc = wr_count;
        wr(3'd0, 32'h3);
        wait_idle("R10");
        rd(3'd2, v); chk("R10 read data", v, 32'h77);
        chk("R10 no write", wr_count, wc);

        // second burst resumes after 0x300
        model[16'h301] = 8'h05; model[16'h302] = 8'h00; model[16'h303] = 8'hE1;
        model[16'h304] = 8'hFF; model[16'h305] = 8'hFF;
        wr(3'd4, 32'h001);
        push_rec(9'h001, 16'h0005, 8'hE1);
        wr(3'd3, 32'h1);
        wait_idle("R6");
        chk("R6 records left", exp_q.size(), 0);
        rd(3'd5, v); chk("R6 last after resume", v, 32'h1_0305);
        rd(3'd3, v); chk("R8 burst bit cleared again", v, 0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule